// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on one output line. A holding register sits in front of a shift register. A host write fills the holding register and clears the empty flag. The shifter then copies the byte on its own and sends it. Because a new byte can wait in the holding register while the current one is shifted out, frames can follow each other with no idle time on the line.

Each frame has a low start bit, then seven or eight data bits sent least significant bit first. An optional extra bit may follow: a parity bit or a multiprocessor flag. The frame ends with one or two high stop bits. Bit timing comes from an external one-cycle baud pulse, and every serial bit lasts one pulse period. Two level interrupt requests are available, each with its own enable: one for an empty holding register and one for a finished transmission.

Top module: `frame_tx`

## Requirements
- R1: After reset, `txd` is 1, `empty_flag` is 1 and `end_flag` is 1.
- R2: A one-cycle `wr_en` stores `wr_data` and `wr_mp` in the holding register. From the next cycle it clears both `empty_flag` and `end_flag`.
- R3: When the line is idle and the holding register is full, the next `baud_tick` copies the byte into the shifter. In that same edge it sets `empty_flag` and starts the start bit. `irq_empty` is high exactly while `empty_flag` and `ie_empty` are both 1.
- R4: A frame is sent in this order: one 0 start bit, then the data bits least significant first. There are 8 data bits when `cfg_seven` is 0 and the low 7 bits when it is 1. Each bit holds for one `baud_tick` period, and `txd` changes only on an edge where `baud_tick` is high.
- R5: `cfg_extra` selects the bit that follows the data: 00 means none, 01 means parity, 10 means the `wr_mp` flag captured with the byte, and 11 means none. The parity bit is the XOR of the data bits actually sent, inverted when `cfg_odd` is 1.
- R6: The frame ends with one stop bit at 1, or two when `cfg_two_stop` is 1.
- R7: If the holding register is full when the last stop bit ends, the next frame's start bit follows at once, with no idle bit between the frames.
- R8: If the holding register is empty when the last stop bit ends, `end_flag` is set and `txd` stays at 1. `irq_end` is high exactly while `end_flag` and `ie_end` are both 1.
- R9: The configuration inputs are captured when a frame is loaded. Changing them while that frame is being sent has no effect on it.
- R10: While `baud_tick` stays low, a frame does not advance and a waiting byte is not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| wr_mp | input | 1 | Multiprocessor flag stored with the byte |
| cfg_seven | input | 1 | 1: seven data bits, 0: eight |
| cfg_extra | input | 2 | Extra bit mode (00 none, 01 parity, 10 mp flag, 11 none) |
| cfg_odd | input | 1 | 1: odd parity, 0: even |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| ie_empty | input | 1 | Enable for `irq_empty` |
| ie_end | input | 1 | Enable for `irq_end` |
| txd | output | 1 | Serial output line, idle high |
| empty_flag | output | 1 | Holding register is free |
| end_flag | output | 1 | Transmission finished, line idle |
| irq_empty | output | 1 | Empty interrupt request |
| irq_end | output | 1 | End interrupt request |

## Verification
A table of frames covers every combination of data width, extra-bit mode, parity sense and stop count that matters. It includes a multiprocessor flag of both 0 and 1, so a wrong bit count, a wrong parity polarity or a dropped extra bit each shows up as a bit mismatch in the received pattern. The table entries are written back to back, and the configuration changes while the previous frame is still on the line. This exposes any idle gap between chained frames and any configuration that is not latched at load. Directed steps hold the baud pulse low after a write, to show that nothing moves without it. They also flip the interrupt enables around the empty and end events.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_EXTRA = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef enum logic [1:0] {
    XB_NONE   = 2'b00,
    XB_PARITY = 2'b01,
    XB_MPFLAG = 2'b10,
    XB_NONE2  = 2'b11
  } xbit_mode_e;

  typedef struct packed {
    logic       seven;
    xbit_mode_e extra;
    logic       odd;
    logic       two_stop;
  } frame_cfg_t;
endpackage

// File: rtl/tx_holdreg.sv
module tx_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mp,
  input  logic              take,
  input  logic              done,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_mp,
  output logic              empty,
  output logic              tx_end
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              mp_q, mp_d;
  logic              empty_q, empty_d;
  logic              end_q, end_d;

  always_comb begin
    data_d  = data_q;
    mp_d    = mp_q;
    empty_d = empty_q;
    end_d   = end_q;
    if (take) empty_d = 1'b1;
    if (done) end_d   = 1'b1;
    if (wr_en) begin
      data_d  = wr_data;
      mp_d    = wr_mp;
      empty_d = 1'b0;
      end_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      mp_q    <= 1'b0;
      empty_q <= 1'b1;
      end_q   <= 1'b1;
    end else begin
      data_q  <= data_d;
      mp_q    <= mp_d;
      empty_q <= empty_d;
      end_q   <= end_d;
    end
  end

  assign hold_data = data_q;
  assign hold_mp   = mp_q;
  assign empty     = empty_q;
  assign tx_end    = end_q;
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              have_data,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_mp,
  input  frame_cfg_t        cfg_in,
  output logic              take,
  output logic              done,
  output logic              txd
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  frame_cfg_t        cfg_q, cfg_d;
  logic              xbit_q, xbit_d;
  logic              has_extra;
  logic [CNT_W-1:0]  data_last;
  logic [CNT_W-1:0]  stop_last;
  logic [DATA_W-1:0] in_mask;

  assign has_extra = (cfg_q.extra == XB_PARITY) || (cfg_q.extra == XB_MPFLAG);
  assign data_last = cfg_q.seven ? LAST_SHORT : LAST_LONG;
  assign stop_last = cfg_q.two_stop ? CNT_W'(1) : CNT_W'(0);
  assign in_mask   = cfg_in.seven ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    cfg_d   = cfg_q;
    xbit_d  = xbit_q;
    take    = 1'b0;
    done    = 1'b0;
    if (tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (have_data) take = 1'b1;
        end
        ST_START: begin
          state_d = ST_DATA;
          cnt_d   = '0;
        end
        ST_DATA: begin
          sh_d = sh_q >> 1;
          if (cnt_q == data_last) begin
            state_d = has_extra ? ST_EXTRA : ST_STOP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_EXTRA: begin
          state_d = ST_STOP;
          cnt_d   = '0;
        end
        ST_STOP: begin
          if (cnt_q == stop_last) begin
            if (have_data) begin
              take = 1'b1;
            end else begin
              done    = 1'b1;
              state_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
    if (take) begin
      state_d = ST_START;
      cnt_d   = '0;
      sh_d    = hold_data;
      cfg_d   = cfg_in;
      xbit_d  = (cfg_in.extra == XB_MPFLAG) ? hold_mp
                                            : ((^(hold_data & in_mask)) ^ cfg_in.odd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      cfg_q   <= '0;
      xbit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      cfg_q   <= cfg_d;
      xbit_q  <= xbit_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = sh_q[0];
      ST_EXTRA: txd = xbit_q;
      default:  txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mp,
  input  logic              cfg_seven,
  input  logic [1:0]        cfg_extra,
  input  logic              cfg_odd,
  input  logic              cfg_two_stop,
  input  logic              ie_empty,
  input  logic              ie_end,
  output logic              txd,
  output logic              empty_flag,
  output logic              end_flag,
  output logic              irq_empty,
  output logic              irq_end
);
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[SYNC_STAGES-1];

  frame_cfg_t        cfg_in;
  logic [DATA_W-1:0] hold_data;
  logic              hold_mp;
  logic              take, done;

  assign cfg_in.seven    = cfg_seven;
  assign cfg_in.extra    = xbit_mode_e'(cfg_extra);
  assign cfg_in.odd      = cfg_odd;
  assign cfg_in.two_stop = cfg_two_stop;

  tx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_mp     (wr_mp),
    .take      (take),
    .done      (done),
    .hold_data (hold_data),
    .hold_mp   (hold_mp),
    .empty     (empty_flag),
    .tx_end    (end_flag)
  );

  tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick      (baud_tick),
    .have_data (!empty_flag),
    .hold_data (hold_data),
    .hold_mp   (hold_mp),
    .cfg_in    (cfg_in),
    .take      (take),
    .done      (done),
    .txd       (txd)
  );

  assign irq_empty = ie_empty & empty_flag;
  assign irq_end   = ie_end & end_flag;
endmodule

// File: rtl/frame_tx_checker.sv
module frame_tx_checker (
  input logic clk,
  input logic rst_core_n,
  input logic baud_tick,
  input logic wr_en,
  input logic txd,
  input logic empty_flag,
  input logic end_flag,
  input logic irq_empty,
  input logic irq_end
);
  a_r2_write_clears: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_en |=> (!empty_flag && !end_flag));

  a_r3_load_starts_frame: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(empty_flag) |-> !txd);

  a_r3_irq_empty_flag: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq_empty |-> empty_flag);

  a_r4_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_core_n)
    !baud_tick |=> $stable(txd));

  a_r8_end_line_high: assert property (@(posedge clk) disable iff (!rst_core_n)
    end_flag |-> txd);

  a_r8_irq_end_flag: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq_end |-> end_flag);
endmodule

bind frame_tx frame_tx_checker u_frame_tx_checker (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .baud_tick  (baud_tick),
  .wr_en      (wr_en),
  .txd        (txd),
  .empty_flag (empty_flag),
  .end_flag   (end_flag),
  .irq_empty  (irq_empty),
  .irq_end    (irq_end)
);

// File: tb/test_frame_tx.sv
module test_frame_tx;
  logic       clk;
  logic       rst_n;
  logic       baud_tick;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       wr_mp;
  logic       cfg_seven;
  logic [1:0] cfg_extra;
  logic       cfg_odd;
  logic       cfg_two_stop;
  logic       ie_empty;
  logic       ie_end;
  logic       txd, empty_flag, end_flag, irq_empty, irq_end;

  int checks = 0;
  int errors = 0;
  bit tick_on = 0;
  int tick_div = 0;

  // vector: {seven, extra[1:0], odd, two_stop, mp, data[7:0]}
  localparam int NVEC = 8;
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 8'hA5},
    {1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 8'hC3},
    {1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 8'h07},
    {1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 8'h3C},
    {1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 8'h81},
    {1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 8'h00},
    {1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 8'hFF},
    {1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 8'hF0}
  };

  logic [11:0] exp_bits [16];
  int          exp_len  [16];
  bit          exp_chain[16];
  int          nexp = 0;

  bit          rx_busy = 0;
  logic [11:0] rx_bits;
  int          rx_n = 0;
  int          rx_frame = 0;
  int          idle_run = 0;
  int          gap_seen = 0;

  frame_tx i_frame_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .wr_mp(wr_mp), .cfg_seven(cfg_seven),
    .cfg_extra(cfg_extra), .cfg_odd(cfg_odd), .cfg_two_stop(cfg_two_stop),
    .ie_empty(ie_empty), .ie_end(ie_end), .txd(txd),
    .empty_flag(empty_flag), .end_flag(end_flag),
    .irq_empty(irq_empty), .irq_end(irq_end)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  initial begin
    baud_tick = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      tick_div = (tick_div == 4) ? 0 : tick_div + 1;
      baud_tick = tick_on && (tick_div == 0);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void build(input logic [13:0] v, output logic [11:0] b, output int n);
    logic [7:0] d;
    logic       par;
    int         nd;
    d  = v[7:0];
    b  = '1;
    n  = 0;
    b[n] = 1'b0; n++;
    nd = v[13] ? 7 : 8;
    for (int i = 0; i < nd; i++) begin b[n] = d[i]; n++; end
    par = (^(d & (v[13] ? 8'h7F : 8'hFF))) ^ v[10];
    if (v[12:11] == 2'b01) begin b[n] = par; n++; end
    else if (v[12:11] == 2'b10) begin b[n] = v[8]; n++; end
    b[n] = 1'b1; n++;
    if (v[9]) begin b[n] = 1'b1; n++; end
  endfunction

  task automatic send(input logic [13:0] v, input bit chained);
    logic [11:0] b;
    int          n;
    build(v, b, n);
    exp_bits[nexp]  = b;
    exp_len[nexp]   = n;
    exp_chain[nexp] = chained;
    nexp++;
    @(posedge clk); #1;
    cfg_seven = v[13]; cfg_extra = v[12:11]; cfg_odd = v[10];
    cfg_two_stop = v[9]; wr_mp = v[8]; wr_data = v[7:0]; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // serial line monitor: one sample per bit, taken in the tick cycle
  always @(negedge clk) begin
    if (rst_n && baud_tick) begin
      if (!rx_busy) begin
        if (txd == 1'b0) begin
          rx_busy = 1; rx_bits = '1; rx_bits[0] = 1'b0; rx_n = 1;
          gap_seen = idle_run;
        end else idle_run++;
      end else begin
        rx_bits[rx_n] = txd;
        rx_n++;
        if (rx_frame >= nexp) begin
          checks++; errors++;
          $display("FAIL R4 unexpected frame actual=%0d expected=%0d", rx_frame, nexp);
          rx_busy = 0; idle_run = 0;
        end else if (rx_n == exp_len[rx_frame]) begin
          // R4 R5 R6 R9: bit pattern of the whole frame
          check("R4/R5/R6/R9 frame bits", 32'(rx_bits & (12'hFFF >> (12 - rx_n))),
                32'(exp_bits[rx_frame] & (12'hFFF >> (12 - rx_n))));
          if (exp_chain[rx_frame]) check("R7 no idle gap", gap_seen, 0);
          rx_frame++; rx_busy = 0; idle_run = 0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wr_mp = 1'b0;
    cfg_seven = 1'b0; cfg_extra = 2'b00; cfg_odd = 1'b0; cfg_two_stop = 1'b0;
    ie_empty = 1'b0; ie_end = 1'b0;
    repeat (4) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 txd idle", txd, 1);
    check("R1 empty", empty_flag, 1);
    check("R1 end", end_flag, 1);
    check("R8 irq_end masked", irq_end, 0);

    // R10: write with no baud pulse, nothing moves
    send({1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 8'h5A}, 1'b0);
    ie_empty = 1'b1;
    repeat (20) @(negedge clk);
    check("R2 empty cleared", empty_flag, 0);
    check("R2 end cleared", end_flag, 0);
    check("R10 line stays high", txd, 1);
    check("R10 still full", empty_flag, 0);
    check("R3 irq_empty while full", irq_empty, 0);

    tick_on = 1;
    wait (empty_flag == 1'b1);
    @(negedge clk);
    check("R3 start bit after load", txd, 0);
    check("R3 irq_empty after load", irq_empty, 1);
    wait (end_flag == 1'b1);
    @(negedge clk);
    check("R8 irq_end disabled", irq_end, 0);
    ie_end = 1'b1;
    @(negedge clk);
    check("R8 irq_end enabled", irq_end, 1);
    check("R8 line high at end", txd, 1);

    // table of frames written back to back
    for (int k = 0; k < NVEC; k++) begin
      wait (empty_flag == 1'b1);
      send(VEC[k], k != 0);
      if (k == 0) begin
        @(negedge clk);
        check("R2 end cleared by write", end_flag, 0);
      end
    end
    wait (end_flag == 1'b1);
    repeat (30) begin
      @(negedge clk);
      if (txd !== 1'b1) check("R8 marking after last frame", txd, 1);
    end
    check("R8 marking after last frame", txd, 1);
    check("R7 all frames received", rx_frame, nexp);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule